// File: doc/BRIEF.md
# Button press-duration classifier

This block watches one active-low push button and decides, for every press, whether it was a quick tap or a long hold. A quick press produces a single-cycle event when the button is let go. A long hold produces a single-cycle event at the moment the hold crosses the one-second mark. After that it produces one repeat pulse for every further full second the button stays down, and no quick-press event is given on release. A second active-low button is handled more simply: each press gives one single-cycle event on its falling edge.

Both raw button inputs can pass through an optional two-flop synchronizer, chosen by a parameter. Debounce is assumed to happen upstream. The number of clock cycles per second is a parameter, so a bench can use a small value. Everything is reset by a synchronous active-high reset and also by a clock-stable input being low. While either of those holds, all event outputs stay low and all timing state is cleared.

Top module: `btn_press_classifier`

## Requirements
- R1: While `rst` is 1 or `clk_ok` is 0, every event output is 0 on every clock edge, whatever the buttons do. The held-time state is cleared.
- R2: A press of the hold button (input value 0 means pressed) that is seen for N consecutive sampled cycles, with N < TICKS_PER_SEC, gives exactly one `short_evt` pulse after release and no `long_evt` or `repeat_evt`.
- R3: For a hold of N >= TICKS_PER_SEC sampled cycles, `long_evt` pulses exactly once, in the cycle after the edge on which the held count reaches TICKS_PER_SEC.
- R4: A hold that reaches the threshold is long, including one released right after the threshold cycle (N == TICKS_PER_SEC). No `short_evt` is produced for it.
- R5: During a long hold, `repeat_evt` pulses once each time the held count reaches another whole multiple of TICKS_PER_SEC. A hold of N cycles gives floor(N/TICKS_PER_SEC)-1 repeats.
- R6: Each press of the tap button (0 means pressed) gives one single-cycle `tap_evt` pulse on its falling edge. Holding it longer and releasing it give no further pulse.
- R7: Every event output is high for one cycle only, and at most one of `short_evt`, `long_evt` and `repeat_evt` is high in any cycle.
- R8: The held-time count clears on release. Two separate presses, each shorter than the threshold, give two short events even if their sum exceeds it.
- R9: With SYNC_EN = 1, a button change driven just before clock edge 1 is first counted on edge 3. So `tap_evt` appears after edge 3, `long_evt` after edge TICKS_PER_SEC+2, and `short_evt` after edge N+3 for a release driven just before edge N+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_ok | input | 1 | High once the clock is stable; low acts as reset |
| hold_btn_n | input | 1 | Hold-classified button, active low |
| tap_btn_n | input | 1 | Plain press-event button, active low |
| short_evt | output | 1 | One-cycle pulse: quick press released |
| long_evt | output | 1 | One-cycle pulse: hold reached one second |
| repeat_evt | output | 1 | One-cycle pulse per further second held |
| tap_evt | output | 1 | One-cycle pulse on tap button press |

## Verification
The bench aims at the threshold boundary. A hold one cycle under the limit must be short, and a hold exactly at it must be long with no short on release. A design with an off-by-one compare would emit the wrong event or both events. Long holds are checked for the exact number and cycle of repeat pulses: a counter that does not wrap after the first second would give none or too many. Back-to-back short presses expose a counter that fails to clear on release, since it would report a false long hold. Holding a button while the clock is not stable catches outputs or counts leaking through the not-locked condition.

// File: rtl/btn_cls_pkg.sv
package btn_cls_pkg;

    typedef struct packed {
        logic quick;
        logic first;
        logic again;
    } hold_evt_t;

    localparam hold_evt_t NO_EVT = '{quick: 1'b0, first: 1'b0, again: 1'b0};

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter bit SYNC_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_n,
    output logic pressed
);
    generate
        if (SYNC_EN) begin : g_two_flop
            logic s1_n, s2_n;
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1_n <= 1'b1;
                    s2_n <= 1'b1;
                end else begin
                    s1_n <= raw_n;
                    s2_n <= s1_n;
                end
            end
            assign pressed = ~s2_n;
        end else begin : g_direct
            assign pressed = ~raw_n;
        end
    endgenerate
endmodule

// File: rtl/hold_timer.sv
module hold_timer
    import btn_cls_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pressed,
    output hold_evt_t evt
);
    localparam int unsigned CW = cnt_width(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] tick_cnt;
    logic          long_seen;
    logic          was_pressed;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt    <= '0;
            long_seen   <= 1'b0;
            was_pressed <= 1'b0;
            evt         <= NO_EVT;
        end else begin
            was_pressed <= pressed;
            evt         <= NO_EVT;
            if (pressed) begin
                if (tick_cnt == LAST) begin
                    tick_cnt  <= '0;
                    long_seen <= 1'b1;
                    if (long_seen) evt.again <= 1'b1;
                    else           evt.first <= 1'b1;
                end else begin
                    tick_cnt <= tick_cnt + 1'b1;
                end
            end else begin
                tick_cnt  <= '0;
                long_seen <= 1'b0;
                if (was_pressed && !long_seen) evt.quick <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/press_edge.sv
module press_edge (
    input  logic clk,
    input  logic rst,
    input  logic pressed,
    output logic pulse
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            prev  <= pressed;
            pulse <= pressed & ~prev;
        end
    end
endmodule

// File: rtl/btn_press_classifier.sv
module btn_press_classifier
    import btn_cls_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 50_000_000,
    parameter bit          SYNC_EN       = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_ok,
    input  logic hold_btn_n,
    input  logic tap_btn_n,
    output logic short_evt,
    output logic long_evt,
    output logic repeat_evt,
    output logic tap_evt
);
    logic      rst_any;
    logic      hold_pressed, tap_pressed;
    hold_evt_t hold_evt;

    assign rst_any = rst | ~clk_ok;

    btn_sync #(.SYNC_EN(SYNC_EN)) u_sync_hold (
        .clk(clk), .rst(rst_any), .raw_n(hold_btn_n), .pressed(hold_pressed)
    );

    btn_sync #(.SYNC_EN(SYNC_EN)) u_sync_tap (
        .clk(clk), .rst(rst_any), .raw_n(tap_btn_n), .pressed(tap_pressed)
    );

    hold_timer #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_timer (
        .clk(clk), .rst(rst_any), .pressed(hold_pressed), .evt(hold_evt)
    );

    press_edge u_tap (
        .clk(clk), .rst(rst_any), .pressed(tap_pressed), .pulse(tap_evt)
    );

    assign short_evt  = hold_evt.quick;
    assign long_evt   = hold_evt.first;
    assign repeat_evt = hold_evt.again;
endmodule

// File: rtl/btn_press_classifier_chk.sv
module btn_press_classifier_chk (
    input logic clk,
    input logic rst_any,
    input logic short_evt,
    input logic long_evt,
    input logic repeat_evt,
    input logic tap_evt
);
    // R1: a cycle under reset or without a stable clock leaves all outputs low
    p_quiet_in_reset_r1: assert property (@(posedge clk)
        rst_any |=> !(short_evt | long_evt | repeat_evt | tap_evt));

    // R7: hold events are mutually exclusive
    p_one_hold_evt_r7: assert property (@(posedge clk) disable iff (rst_any)
        $onehot0({short_evt, long_evt, repeat_evt}));

    // R7: single-cycle pulses
    p_short_single_r7: assert property (@(posedge clk) disable iff (rst_any)
        short_evt |=> !short_evt);
    p_long_single_r7: assert property (@(posedge clk) disable iff (rst_any)
        long_evt |=> !long_evt);
    p_tap_single_r6: assert property (@(posedge clk) disable iff (rst_any)
        tap_evt |=> !tap_evt);

    // R4: a hold that reached the threshold never gives a short event next
    p_no_short_after_long_r4: assert property (@(posedge clk) disable iff (rst_any)
        long_evt |=> !short_evt);

    // R5: a repeat is never followed directly by the first-threshold event
    p_no_long_after_repeat_r5: assert property (@(posedge clk) disable iff (rst_any)
        repeat_evt |=> !long_evt);
endmodule

bind btn_press_classifier btn_press_classifier_chk u_chk (
    .clk(clk), .rst_any(rst_any), .short_evt(short_evt), .long_evt(long_evt),
    .repeat_evt(repeat_evt), .tap_evt(tap_evt)
);

// File: tb/btn_press_classifier_bench.sv
module btn_press_classifier_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_ok = 1'b1;
    logic hold_btn_n = 1'b1;
    logic tap_btn_n = 1'b1;
    logic short_evt, long_evt, repeat_evt, tap_evt;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int edge_n = 0;
    int n_short, n_long, n_rpt, n_tap, n_bad;
    int short_at, long_at, rpt_at, tap_at;
    logic [3:0] prev_out = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btn_press_classifier #(.TICKS_PER_SEC(T), .SYNC_EN(1'b1)) u_btn_press_classifier (
        .clk(clk), .rst(rst), .clk_ok(clk_ok),
        .hold_btn_n(hold_btn_n), .tap_btn_n(tap_btn_n),
        .short_evt(short_evt), .long_evt(long_evt),
        .repeat_evt(repeat_evt), .tap_evt(tap_evt)
    );

    always @(posedge clk) edge_n <= edge_n + 1;

    always @(negedge clk) begin
        logic [3:0] cur;
        cur = {short_evt, long_evt, repeat_evt, tap_evt};
        if (short_evt)  begin n_short++; if (short_at < 0) short_at = edge_n; end
        if (long_evt)   begin n_long++;  if (long_at  < 0) long_at  = edge_n; end
        if (repeat_evt) begin n_rpt++;   if (rpt_at   < 0) rpt_at   = edge_n; end
        if (tap_evt)    begin n_tap++;   if (tap_at   < 0) tap_at   = edge_n; end
        if ($countones(cur[3:1]) > 1 || (cur & prev_out) != 4'b0) n_bad++;
        prev_out = cur;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start_window();
        @(negedge clk);
        #1;
        edge_n = 0;
        n_short = 0; n_long = 0; n_rpt = 0; n_tap = 0;
        short_at = -1; long_at = -1; rpt_at = -1; tap_at = -1;
    endtask

    task automatic release_hold_after(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1 hold_btn_n = 1'b1;
    endtask

    task automatic flush();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        start_window();
        hold_btn_n = 1'b0;
        tap_btn_n  = 1'b0;
        repeat (3*T) @(posedge clk);
        @(negedge clk);
        #1 hold_btn_n = 1'b1; tap_btn_n = 1'b1;
        flush();
        chk(n_short + n_long + n_rpt + n_tap == 0, "R1 reset quiet", n_short + n_long + n_rpt + n_tap, 0);
        rst = 1'b0;
        flush();
    endtask

    task automatic t_short_press(input int n, input string tag);
        start_window();
        hold_btn_n = 1'b0;
        release_hold_after(n);
        flush();
        chk(n_short == 1, {tag, " short count"}, n_short, 1);
        chk(short_at == n + 3, {tag, " R9 short timing"}, short_at, n + 3);
        chk(n_long + n_rpt == 0, {tag, " no long/repeat"}, n_long + n_rpt, 0);
    endtask

    task automatic t_exact_threshold();
        start_window();
        hold_btn_n = 1'b0;
        release_hold_after(T);
        flush();
        chk(n_long == 1, "R3 long count", n_long, 1);
        chk(long_at == T + 2, "R3 R9 long timing", long_at, T + 2);
        chk(n_short == 0, "R4 no short at threshold", n_short, 0);
        chk(n_rpt == 0, "R5 no repeat at threshold", n_rpt, 0);
    endtask

    task automatic t_long_repeat();
        start_window();
        hold_btn_n = 1'b0;
        release_hold_after(3*T + 4);
        flush();
        chk(n_long == 1, "R3 single long in long hold", n_long, 1);
        chk(n_rpt == 2, "R5 repeat count", n_rpt, 2);
        chk(rpt_at == 2*T + 2, "R5 first repeat timing", rpt_at, 2*T + 2);
        chk(n_short == 0, "R4 no short after long hold", n_short, 0);
    endtask

    task automatic t_two_shorts();
        start_window();
        hold_btn_n = 1'b0;
        release_hold_after(T - 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 hold_btn_n = 1'b0;
        release_hold_after(T - 1);
        flush();
        chk(n_short == 2, "R8 two short presses", n_short, 2);
        chk(n_long == 0, "R8 counter cleared, no long", n_long, 0);
    endtask

    task automatic t_tap();
        start_window();
        tap_btn_n = 1'b0;
        repeat (2*T) @(posedge clk);
        @(negedge clk);
        chk(n_tap == 1, "R6 tap single pulse while held", n_tap, 1);
        chk(tap_at == 3, "R6 R9 tap timing", tap_at, 3);
        #1 tap_btn_n = 1'b1;
        flush();
        chk(n_tap == 1, "R6 no tap on release", n_tap, 1);
        chk(n_short + n_long + n_rpt == 0, "R6 tap leaves hold path idle", n_short + n_long + n_rpt, 0);
    endtask

    task automatic t_unlocked();
        clk_ok = 1'b0;
        start_window();
        hold_btn_n = 1'b0;
        tap_btn_n  = 1'b0;
        repeat (3*T) @(posedge clk);
        @(negedge clk);
        #1 hold_btn_n = 1'b1; tap_btn_n = 1'b1;
        flush();
        clk_ok = 1'b1;
        flush();
        chk(n_short + n_long + n_rpt + n_tap == 0, "R1 not-locked quiet", n_short + n_long + n_rpt + n_tap, 0);
    endtask

    initial begin
        n_bad = 0;
        rst = 1'b1;
        repeat (4) @(posedge clk);
        t_reset();
        t_short_press(4, "R2 brief");
        t_short_press(T - 1, "R2 just under threshold");
        t_exact_threshold();
        t_long_repeat();
        t_two_shorts();
        t_tap();
        t_unlocked();
        chk(n_bad == 0, "R7 single-cycle exclusive events", n_bad, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule